// File: doc/BRIEF.md
# Segmented LRU Replacement State for One Cache Set

This block holds the replacement state of a single set of an associative cache. The ways of the set are split into two recency-ordered groups. A probationary group receives freshly filled lines. A protected group receives lines that have been hit. The protected group can hold at most `PROT_MAX` ways. When a hit would overfill it, the protected group's least-recent line is pushed back to the most-recent end of the probationary group. That line then gets another chance before it can be evicted.

The caller performs the tag compare and the data movement. It tells the block about each access with a strobe, a hit flag and the way index involved: the hit way on a hit, or the refilled way on a miss. The block always presents the way that the next miss should replace. The caller normally refills the presented way, but it may name any way, and that way is then moved as a fill. The victim output is a function of the stored state only, so it updates in the cycle after the access edge.

Top module: `slru_set_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every way is probationary. Way 0 is least recent and way `NWAYS-1` is most recent, so `victim_way` reads 0. Refilling the presented victim repeatedly yields ways 0, 1, 2, … in index order.
- R2: An access with `acc_hit`=0 (fill) places `acc_way` at the most-recent end of the probationary group. The other probationary ways keep their relative order.
- R3: An access with `acc_hit`=1 on a probationary way, while the protected group holds fewer than `PROT_MAX` ways, moves that way to the most-recent end of the protected group. The protected count grows by one.
- R4: A hit on a probationary way while the protected group already holds `PROT_MAX` ways inserts the hit way as protected most-recent. The protected least-recent way moves to the probationary most-recent position.
- R5: A hit on a way that is already protected only moves it to the protected most-recent position. No way is demoted and the probationary order is unchanged.
- R6: `victim_way` always equals the least-recent way of the probationary group whenever that group is non-empty.
- R7: The protected group never holds more than `PROT_MAX` ways. With the defaults, the probationary group therefore keeps at least `NWAYS-PROT_MAX` ways.
- R8: When every way is protected (possible only with `PROT_MAX`=`NWAYS`), `victim_way` is the least-recent protected way.
- R9: A fill naming a protected way removes it from the protected group and places it at the probationary most-recent position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_hit | input | 1 | 1: hit on `acc_way`; 0: `acc_way` was refilled after a miss |
| acc_way | input | WAY_W | Way index of the access |
| victim_way | output | WAY_W | Way to replace on the next miss |

## Verification
Several properties are checked on every cycle:

- The stored order remains a permutation of the ways.
- The protected count stays within its limit.
- A hit or fill way never becomes the next victim while another candidate exists.
- A protected hit keeps the count and the victim unchanged.
- A saturated promotion lands the old protected tail at the probationary head.

The exact eviction sequences that follow mixed hits, demotions and out-of-order fills can only be shown by the bench's scenarios. The bench reads out the probationary order by repeatedly refilling the presented victim. The all-protected fallback is also shown by a scenario, on a second instance whose limit equals the way count.

// File: rtl/slru_pkg.sv
// Package: shared types for the segmented LRU set controller.
// Assumes nothing beyond IEEE 1800-2017.
package slru_pkg;

    // Kind of reordering applied to the recency list in one cycle.
    typedef enum logic [1:0] {
        MV_NONE    = 2'd0,  // list unchanged
        MV_PROMOTE = 2'd1,  // hit: move to protected head
        MV_FILL    = 2'd2   // fill: move to probationary head
    } move_e;

endpackage

// File: rtl/slru_locate.sv
// Module: slru_locate
// Finds the list position that currently holds a given way index.
// Assumes the list is a permutation, so at most one position matches.
module slru_locate #(
    parameter int NWAYS = 8,
    parameter int WAY_W = 3
) (
    input  logic [NWAYS-1:0][WAY_W-1:0] order,
    input  logic [WAY_W-1:0]            way,
    output logic                        found,
    output logic [WAY_W-1:0]            pos
);

    logic [NWAYS-1:0] match;

    // One comparator per list position.
    for (genvar i = 0; i < NWAYS; i++) begin : g_cmp
        assign match[i] = (order[i] == way);
    end

    // Encode the matching position (one-hot by the permutation property).
    always_comb begin
        pos = '0;
        for (int i = 0; i < NWAYS; i++) begin
            if (match[i]) pos = WAY_W'(i);
        end
        found = |match;
    end

endmodule

// File: rtl/slru_seg_ctrl.sv
// Module: slru_seg_ctrl
// Decides where an accessed way must move in the combined recency list
// and how the protected count changes. List positions [0, prot_cnt) are
// protected (position 0 most recent); the rest are probationary, with the
// last position least recent. Assumes 1 <= PROT_MAX <= NWAYS.
module slru_seg_ctrl
    import slru_pkg::*;
#(
    parameter int NWAYS    = 8,
    parameter int PROT_MAX = 3,
    parameter int WAY_W    = 3,
    parameter int CNT_W    = 4
) (
    input  logic             acc_valid,
    input  logic             acc_hit,
    input  logic             found,
    input  logic [WAY_W-1:0] src_pos,
    input  logic [CNT_W-1:0] prot_cnt,
    output move_e            kind,
    output logic [WAY_W-1:0] tgt_pos,
    output logic [CNT_W-1:0] prot_cnt_nxt
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PROT_MAX);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic in_prot;

    // Classify the access and pick the target position and new count.
    always_comb begin
        in_prot      = (CNT_W'(src_pos) < prot_cnt);
        kind         = MV_NONE;
        tgt_pos      = src_pos;
        prot_cnt_nxt = prot_cnt;
        if (acc_valid && found) begin
            if (acc_hit) begin
                // A hit always lands at the protected head. When the
                // group is full, the shift pushes its tail across the
                // boundary, which is exactly the demotion.
                kind    = MV_PROMOTE;
                tgt_pos = '0;
                if (!in_prot && (prot_cnt < LIMIT)) begin
                    prot_cnt_nxt = prot_cnt + ONE;
                end
            end else begin
                kind = MV_FILL;
                if (in_prot) begin
                    prot_cnt_nxt = prot_cnt - ONE;
                    tgt_pos      = WAY_W'(prot_cnt - ONE);
                end else begin
                    tgt_pos      = WAY_W'(prot_cnt);
                end
            end
        end
    end

endmodule

// File: rtl/slru_reorder.sv
// Module: slru_reorder
// Removes the entry at src and reinserts it at tgt, shifting the entries
// in between by one place. Assumes src and tgt are valid positions.
module slru_reorder #(
    parameter int NWAYS = 8,
    parameter int WAY_W = 3
) (
    input  logic                        en,
    input  logic [NWAYS-1:0][WAY_W-1:0] cur,
    input  logic [WAY_W-1:0]            way,
    input  logic [WAY_W-1:0]            src,
    input  logic [WAY_W-1:0]            tgt,
    output logic [NWAYS-1:0][WAY_W-1:0] nxt
);

    // Per-position three-way select: keep, take the moved way, or shift.
    always_comb begin
        int s;
        int t;
        s = int'(src);
        t = int'(tgt);
        for (int i = 0; i < NWAYS; i++) begin
            nxt[i] = cur[i];
            if (en) begin
                if (t <= s) begin
                    // Move toward the head: entries in [t, s) slide down.
                    if (i == t)                nxt[i] = way;
                    else if (i > t && i <= s)  nxt[i] = cur[(i > 0) ? i - 1 : 0];
                end else begin
                    // Move toward the tail: entries in (s, t] slide up.
                    if (i == t)                nxt[i] = way;
                    else if (i >= s && i < t)  nxt[i] = cur[(i < NWAYS - 1) ? i + 1 : NWAYS - 1];
                end
            end
        end
    end

endmodule

// File: rtl/slru_set_ctrl.sv
// Module: slru_set_ctrl (top)
// Segmented LRU replacement state for one cache set. Holds a single list
// of all way indices ordered protected-head .. protected-tail,
// probationary-head .. probationary-tail, plus the protected count. The
// victim is the last list entry. Assumes 1 <= PROT_MAX <= NWAYS and at
// most one access per cycle; the caller supplies way indices.
module slru_set_ctrl
    import slru_pkg::*;
#(
    parameter int NWAYS    = 8,
    parameter int PROT_MAX = 3,
    localparam int WAY_W   = (NWAYS > 1) ? $clog2(NWAYS) : 1,
    localparam int CNT_W   = $clog2(NWAYS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_hit,
    input  logic [WAY_W-1:0] acc_way,
    output logic [WAY_W-1:0] victim_way
);

    logic [NWAYS-1:0][WAY_W-1:0] order_q;
    logic [NWAYS-1:0][WAY_W-1:0] order_d;
    logic [CNT_W-1:0]            prot_cnt_q;
    logic [CNT_W-1:0]            prot_cnt_d;
    logic                        found;
    logic [WAY_W-1:0]            src_pos;
    logic [WAY_W-1:0]            tgt_pos;
    move_e                       kind;

    slru_locate #(
        .NWAYS (NWAYS),
        .WAY_W (WAY_W)
    ) u_locate (
        .order (order_q),
        .way   (acc_way),
        .found (found),
        .pos   (src_pos)
    );

    slru_seg_ctrl #(
        .NWAYS    (NWAYS),
        .PROT_MAX (PROT_MAX),
        .WAY_W    (WAY_W),
        .CNT_W    (CNT_W)
    ) u_seg (
        .acc_valid    (acc_valid),
        .acc_hit      (acc_hit),
        .found        (found),
        .src_pos      (src_pos),
        .prot_cnt     (prot_cnt_q),
        .kind         (kind),
        .tgt_pos      (tgt_pos),
        .prot_cnt_nxt (prot_cnt_d)
    );

    slru_reorder #(
        .NWAYS (NWAYS),
        .WAY_W (WAY_W)
    ) u_reorder (
        .en  (kind != MV_NONE),
        .cur (order_q),
        .way (acc_way),
        .src (src_pos),
        .tgt (tgt_pos),
        .nxt (order_d)
    );

    // State register: reset to all-probationary, way 0 at the tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NWAYS; i++) begin
                order_q[i] <= WAY_W'(NWAYS - 1 - i);
            end
            prot_cnt_q <= '0;
        end else begin
            order_q    <= order_d;
            prot_cnt_q <= prot_cnt_d;
        end
    end

    // The tail of the list is the replacement candidate.
    assign victim_way = order_q[NWAYS-1];

endmodule

// File: rtl/slru_set_chk.sv
// Module: slru_set_chk
// Property checker for slru_set_ctrl, attached with bind below.
// Observes the ports plus the stored list, count and located position.
module slru_set_chk #(
    parameter int NWAYS    = 8,
    parameter int PROT_MAX = 3,
    parameter int WAY_W    = 3,
    parameter int CNT_W    = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        acc_valid,
    input logic                        acc_hit,
    input logic [WAY_W-1:0]            acc_way,
    input logic [WAY_W-1:0]            victim_way,
    input logic [NWAYS-1:0][WAY_W-1:0] order_q,
    input logic [CNT_W-1:0]            prot_cnt_q,
    input logic                        found,
    input logic [WAY_W-1:0]            src_pos
);

    logic [NWAYS-1:0] present;
    logic             in_prot;
    int               prob_len;

    // Mark every way index seen anywhere in the list.
    always_comb begin
        present = '0;
        for (int i = 0; i < NWAYS; i++) begin
            present[int'(order_q[i])] = 1'b1;
        end
        in_prot  = found && (CNT_W'(src_pos) < prot_cnt_q);
        prob_len = NWAYS - int'(prot_cnt_q);
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        ($past(!rst_n) && rst_n) |-> (victim_way == '0 && prot_cnt_q == '0)); // R1

    AST_ORDER_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        &present); // R2

    AST_FILL_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hit && prob_len >= 2) |=> (victim_way != $past(acc_way))); // R2

    AST_PROMOTE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit && found && !in_prot && int'(prot_cnt_q) < PROT_MAX)
        |=> (prot_cnt_q == $past(prot_cnt_q) + CNT_W'(1))); // R3

    AST_HIT_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit) |=> (victim_way != $past(acc_way))); // R3

    AST_PROT_HIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit && in_prot && prob_len > 0)
        |=> ($stable(prot_cnt_q) && $stable(victim_way))); // R5

    AST_PROT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(prot_cnt_q) <= PROT_MAX); // R7

    if (PROT_MAX < NWAYS) begin : g_demote
        AST_DEMOTE_TO_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && acc_hit && found && !in_prot && int'(prot_cnt_q) == PROT_MAX)
            |=> (order_q[PROT_MAX] == $past(order_q[PROT_MAX-1]))); // R4
    end

endmodule

bind slru_set_ctrl slru_set_chk #(
    .NWAYS    (NWAYS),
    .PROT_MAX (PROT_MAX),
    .WAY_W    (WAY_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_hit    (acc_hit),
    .acc_way    (acc_way),
    .victim_way (victim_way),
    .order_q    (order_q),
    .prot_cnt_q (prot_cnt_q),
    .found      (found),
    .src_pos    (src_pos)
);

// File: tb/tb_slru_set_ctrl.sv
// Directed bench for slru_set_ctrl: one task per scenario, plus a model
// comparison over a pseudo-random access stream.
module tb_slru_set_ctrl;

    localparam int N  = 8;
    localparam int PM = 3;
    localparam int NF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_hit = 1'b0;
    logic [2:0] acc_way = '0;
    logic [2:0] victim_way;
    logic       f_valid = 1'b0;
    logic       f_hit = 1'b0;
    logic [1:0] f_way = '0;
    logic [1:0] f_victim;

    int n_chk  = 0;
    int n_fail = 0;

    // Independent model: two lists, index 0 is most recent.
    int m_prot[N];
    int m_prob[N];
    int m_pn;
    int m_bn;

    always #4 clk = ~clk;

    slru_set_ctrl #(.NWAYS(N), .PROT_MAX(PM)) dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
        .acc_way(acc_way), .victim_way(victim_way));

    slru_set_ctrl #(.NWAYS(NF), .PROT_MAX(NF)) dut_full (
        .clk(clk), .rst_n(rst_n), .acc_valid(f_valid), .acc_hit(f_hit),
        .acc_way(f_way), .victim_way(f_victim));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit m_take(input int w);
        for (int i = 0; i < m_pn; i++) if (m_prot[i] == w) begin
            for (int j = i; j < m_pn - 1; j++) m_prot[j] = m_prot[j+1];
            m_pn--;
            return 1'b1;
        end
        for (int i = 0; i < m_bn; i++) if (m_prob[i] == w) begin
            for (int j = i; j < m_bn - 1; j++) m_prob[j] = m_prob[j+1];
            m_bn--;
            return 1'b0;
        end
        return 1'b0;
    endfunction

    function automatic void m_push_prot(input int w);
        for (int j = m_pn; j > 0; j--) m_prot[j] = m_prot[j-1];
        m_prot[0] = w;
        m_pn++;
    endfunction

    function automatic void m_push_prob(input int w);
        for (int j = m_bn; j > 0; j--) m_prob[j] = m_prob[j-1];
        m_prob[0] = w;
        m_bn++;
    endfunction

    function automatic int m_victim();
        return (m_bn > 0) ? m_prob[m_bn-1] : m_prot[m_pn-1];
    endfunction

    function automatic void m_apply(input bit h, input int w);
        bit was;
        int d;
        was = m_take(w);
        if (!h) m_push_prob(w);
        else if (was || m_pn < PM) m_push_prot(w);
        else begin
            d = m_prot[m_pn-1];
            m_pn--;
            m_push_prot(w);
            m_push_prob(d);
        end
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_pn = 0;
        m_bn = N;
        for (int i = 0; i < N; i++) m_prob[i] = N - 1 - i;
        @(negedge clk);
    endtask

    // One access on the main instance; victim compared with the model (R6).
    task automatic access(input bit h, input int w);
        acc_valid = 1'b1;
        acc_hit   = h;
        acc_way   = 3'(w);
        @(negedge clk);
        acc_valid = 1'b0;
        m_apply(h, w);
        chk("R6 victim vs model", int'(victim_way), m_victim());
    endtask

    task automatic access_f(input bit h, input int w);
        f_valid = 1'b1;
        f_hit   = h;
        f_way   = 2'(w);
        @(negedge clk);
        f_valid = 1'b0;
    endtask

    // Read out the victim order by refilling the presented victim.
    task automatic expect_seq(input string req, input int exp[N], input int n);
        for (int k = 0; k < n; k++) begin
            chk(req, int'(victim_way), exp[k]);
            access(1'b0, int'(victim_way));
        end
    endtask

    task automatic t_reset();
        int e[N] = '{0, 1, 2, 3, 4, 5, 6, 7};
        do_reset();
        chk("R1 reset victim", int'(victim_way), 0);
        expect_seq("R1 index order after reset", e, N);
    endtask

    task automatic t_fill_order();
        int e[N] = '{1, 2, 3, 4, 6, 7, 0, 5};
        do_reset();
        access(1'b0, 0);
        chk("R2 filled way leaves tail", int'(victim_way), 1);
        access(1'b0, 5);
        expect_seq("R2 fill to probationary head", e, N);
    endtask

    task automatic t_promote();
        do_reset();
        access(1'b1, 0);
        chk("R3 promoted way not victim", int'(victim_way), 1);
        access(1'b1, 1);
        chk("R3 second promotion", int'(victim_way), 2);
    endtask

    task automatic t_demote();
        int e[N] = '{4, 5, 6, 7, 0, 0, 0, 0};
        do_reset();
        access(1'b1, 0);
        access(1'b1, 1);
        access(1'b1, 2);
        access(1'b1, 3);
        expect_seq("R4 protected tail demoted to head", e, 5);
    endtask

    task automatic t_prot_hit();
        int e[N] = '{3, 5, 6, 7, 1, 0, 0, 0};
        do_reset();
        access(1'b1, 0);
        access(1'b1, 1);
        access(1'b1, 2);
        access(1'b1, 0);
        chk("R5 protected hit keeps victim", int'(victim_way), 3);
        access(1'b1, 4);
        expect_seq("R5 reordered protected tail", e, 5);
    endtask

    task automatic t_limit();
        int e[N] = '{6, 7, 0, 1, 2, 6, 0, 0};
        do_reset();
        for (int w = 0; w < 6; w++) access(1'b1, w);
        expect_seq("R7 probationary size holds", e, 6);
    endtask

    task automatic t_all_prot();
        do_reset();
        chk("R1 full-limit instance reset", int'(f_victim), 0);
        for (int w = 0; w < NF; w++) access_f(1'b1, w);
        chk("R8 all protected victim", int'(f_victim), 0);
        access_f(1'b0, 0);
        chk("R9 fill of protected way", int'(f_victim), 0);
        access_f(1'b1, 1);
        chk("R9 protected hit after fill", int'(f_victim), 0);
        access_f(1'b1, 0);
        chk("R8 victim back to protected tail", int'(f_victim), 2);
    endtask

    task automatic t_random();
        logic [15:0] lfsr = 16'hACE1;
        do_reset();
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            access(lfsr[3] & lfsr[5], int'(lfsr[2:0]));
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_order();
        t_promote();
        t_demote();
        t_prot_hit();
        t_limit();
        t_all_prot();
        t_random();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule